// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets a clocked host perform single-word reads and writes on an asynchronous static RAM. The host presents an address, a direction and, for writes, a data word. When the controller is idle it accepts the request and generates the active-low chip-enable, write-enable and output-enable strobes. It also drives the memory address and the shared bidirectional data bus. All strobes come straight from flip-flops, so their edges line up with the clock.

Each access lasts a whole number of clock cycles. These counts are parameters, found by rounding the memory's access and cycle times up to clock periods. A read captures the bus on its last strobed cycle and hands the word back with a one-cycle valid pulse. A write ends on either the write-enable edge or the chip-enable edge, chosen by a parameter. Address and data are held for one more cycle after that edge. After every read a turnaround gap follows. During the gap the memory's outputs are switched off before the controller may drive the bus again.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, mem_ce_n, mem_we_n and mem_oe_n are all 1, req_ready is 1 and rd_valid is 0.
- R2: mem_ce_n is 1 in every cycle where req_ready is 1, so the memory sits in standby between accesses.
- R3: A read accepted at a clock edge (req_valid=1, req_write=0, req_ready=1) holds mem_ce_n=0, mem_oe_n=0 and mem_we_n=1 for exactly RD_CYC cycles, starting with the cycle after acceptance. mem_addr equals the request address throughout.
- R4: In the cycle right after the last read cycle, rd_valid is 1 for exactly one cycle. rd_data equals the word the memory presented during that last read cycle.
- R5: A write accepted at a clock edge (req_write=1) holds mem_ce_n=0 and mem_we_n=0 for exactly WR_CYC cycles, starting with the cycle after acceptance. mem_oe_n stays 1 for the whole write.
- R6: With WR_MODE=0 the write ends with mem_we_n rising while mem_ce_n stays 0 for one more cycle. With WR_MODE=1 it ends with mem_ce_n rising while mem_we_n stays 0 for one more cycle.
- R7: mem_addr and the driven data word stay unchanged from acceptance until the cycle after the terminating edge, that is, while either mem_ce_n or mem_we_n is 0.
- R8: The controller never drives mem_dq in a cycle where the memory drives it (mem_ce_n=0, mem_oe_n=0, mem_we_n=1).
- R9: After a read, req_ready stays 0 for TA_CYC (at least 1) further cycles, with all strobes at 1 and the data driver off. A write requested during the read therefore first lowers mem_we_n in cycle RD_CYC+TA_CYC+2, counting the read's first strobed cycle as cycle 1.
- R10: req_ready is 0 while an access or turnaround is in progress. A request presented while req_ready is 0 is ignored and changes no memory word.
- R11: A read of an address returns the last word written there, for both write termination modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Request word address |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | Controller idle; a request is taken at this edge |
| rd_valid | output | 1 | One-cycle pulse: rd_data holds read data |
| rd_data | output | DW | Captured read word |
| mem_addr | output | AW | Memory address |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_dq | inout | DW | Bidirectional memory data bus |

## Verification
The end of a read, where data is captured and output enable rises, can fall in the same cycle that a pending write would otherwise start its drive. The bench provokes this by holding a write request asserted from the first cycle of a read. It then judges the result on three points. The returned word must be correct. The write strobe must fall in exactly the cycle the turnaround rule predicts. A behavioural memory model, which follows the enable truth table, must never see the bus differ from the word it is driving.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RD   = 3'd1,
    ST_WR   = 3'd2,
    ST_WEND = 3'd3,
    ST_TURN = 3'd4
  } ctl_state_t;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/asram_cnt.sv
module asram_cnt #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - W'(1);
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/asram_fsm.sv
module asram_fsm
  import asram_pkg::*;
#(
  parameter int RD_CYC  = 3,
  parameter int WR_CYC  = 3,
  parameter int TA_CYC  = 1,
  parameter int WR_MODE = 0,
  parameter int CW      = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          cnt_zero,
  output logic          cnt_load,
  output logic [CW-1:0] cnt_val,
  output logic          req_ready,
  output logic          acc_rd,
  output logic          acc_wr,
  output logic          rd_last,
  output logic          wr_hold,
  output logic          ce_n,
  output logic          we_n,
  output logic          oe_n
);

  ctl_state_t state_q;
  logic       term_ce;

  generate
    if (WR_MODE != 0) begin : g_ce_term
      assign term_ce = 1'b1;
    end else begin : g_we_term
      assign term_ce = 1'b0;
    end
  endgenerate

  assign req_ready = (state_q == ST_IDLE);
  assign acc_rd    = req_ready && req_valid && !req_write;
  assign acc_wr    = req_ready && req_valid && req_write;
  assign rd_last   = (state_q == ST_RD) && cnt_zero;
  assign wr_hold   = (state_q == ST_WEND);

  always_comb begin
    cnt_load = 1'b0;
    cnt_val  = '0;
    if (acc_rd) begin
      cnt_load = 1'b1;
      cnt_val  = CW'(RD_CYC - 1);
    end else if (acc_wr) begin
      cnt_load = 1'b1;
      cnt_val  = CW'(WR_CYC - 1);
    end else if (rd_last) begin
      cnt_load = 1'b1;
      cnt_val  = CW'(TA_CYC - 1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      ce_n    <= 1'b1;
      we_n    <= 1'b1;
      oe_n    <= 1'b1;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (acc_wr) begin
            ce_n    <= 1'b0;
            we_n    <= 1'b0;
            state_q <= ST_WR;
          end else if (acc_rd) begin
            ce_n    <= 1'b0;
            oe_n    <= 1'b0;
            state_q <= ST_RD;
          end
        end
        ST_RD: begin
          if (cnt_zero) begin
            ce_n    <= 1'b1;
            oe_n    <= 1'b1;
            state_q <= ST_TURN;
          end
        end
        ST_TURN: begin
          if (cnt_zero) begin
            state_q <= ST_IDLE;
          end
        end
        ST_WR: begin
          if (cnt_zero) begin
            if (term_ce) begin
              ce_n <= 1'b1;
            end else begin
              we_n <= 1'b1;
            end
            state_q <= ST_WEND;
          end
        end
        ST_WEND: begin
          ce_n    <= 1'b1;
          we_n    <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: begin
          ce_n    <= 1'b1;
          we_n    <= 1'b1;
          oe_n    <= 1'b1;
          state_q <= ST_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/asram_io.sv
module asram_io #(
  parameter int AW = 15,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc_rd,
  input  logic          acc_wr,
  input  logic          rd_last,
  input  logic          wr_hold,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic [AW-1:0] mem_addr,
  inout  wire  [DW-1:0] mem_dq,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          drv_en
);

  logic [DW-1:0] wdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr <= '0;
      wdata_q  <= '0;
    end else begin
      if (acc_rd || acc_wr) begin
        mem_addr <= req_addr;
      end
      if (acc_wr) begin
        wdata_q <= req_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      drv_en <= 1'b0;
    end else if (acc_wr) begin
      drv_en <= 1'b1;
    end else if (wr_hold) begin
      drv_en <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_last;
      if (rd_last) begin
        rd_data <= mem_dq;
      end
    end
  end

  assign mem_dq = drv_en ? wdata_q : {DW{1'bz}};

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int AW      = 15,
  parameter int DW      = 8,
  parameter int RD_CYC  = 3,
  parameter int WR_CYC  = 3,
  parameter int TA_CYC  = 1,
  parameter int WR_MODE = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  inout  wire  [DW-1:0] mem_dq
);

  localparam int MAXC = max3(RD_CYC, WR_CYC, TA_CYC);
  localparam int CW   = $clog2(MAXC + 1);

  initial begin
    if (RD_CYC < 1 || WR_CYC < 1 || TA_CYC < 1) begin
      $error("asram_ctrl: cycle counts must be at least 1");
    end
  end

  logic          cnt_load;
  logic [CW-1:0] cnt_val;
  logic          cnt_zero;
  logic          acc_rd;
  logic          acc_wr;
  logic          rd_last;
  logic          wr_hold;
  logic          drv_en;

  asram_cnt #(.W(CW)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (cnt_load),
    .load_val (cnt_val),
    .zero     (cnt_zero)
  );

  asram_fsm #(
    .RD_CYC  (RD_CYC),
    .WR_CYC  (WR_CYC),
    .TA_CYC  (TA_CYC),
    .WR_MODE (WR_MODE),
    .CW      (CW)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .cnt_zero  (cnt_zero),
    .cnt_load  (cnt_load),
    .cnt_val   (cnt_val),
    .req_ready (req_ready),
    .acc_rd    (acc_rd),
    .acc_wr    (acc_wr),
    .rd_last   (rd_last),
    .wr_hold   (wr_hold),
    .ce_n      (mem_ce_n),
    .we_n      (mem_we_n),
    .oe_n      (mem_oe_n)
  );

  asram_io #(.AW(AW), .DW(DW)) u_io (
    .clk       (clk),
    .rst       (rst),
    .acc_rd    (acc_rd),
    .acc_wr    (acc_wr),
    .rd_last   (rd_last),
    .wr_hold   (wr_hold),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .mem_addr  (mem_addr),
    .mem_dq    (mem_dq),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .drv_en    (drv_en)
  );

endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
  parameter int AW      = 15,
  parameter int WR_MODE = 0
) (
  input logic          clk,
  input logic          rst,
  input logic          req_ready,
  input logic          rd_valid,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ce_n,
  input logic          mem_we_n,
  input logic          mem_oe_n,
  input logic          drv_en
);

  // R2: standby whenever idle
  p_idle_standby_r2: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> mem_ce_n);

  // R3: output enable only inside a read
  p_read_strobes_r3: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> (!mem_ce_n && mem_we_n));

  // R4: valid pulse follows end of read and lasts one cycle
  p_valid_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);

  p_valid_after_read_r4: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $rose(mem_oe_n));

  // R5: output enable stays off while writing
  p_write_no_oe_r5: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> mem_oe_n);

  // R6: terminating strobe order
  generate
    if (WR_MODE == 0) begin : g_m0
      p_we_first_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> !mem_ce_n);
    end else begin : g_m1
      p_ce_first_r6: assert property (@(posedge clk) disable iff (rst)
        ($rose(mem_ce_n) && $past(mem_oe_n)) |-> !mem_we_n);
    end
  endgenerate

  // R7: address held while a write strobe is active
  p_addr_hold_r7: assert property (@(posedge clk) disable iff (rst)
    ((!mem_ce_n || !mem_we_n) && $past(!mem_ce_n || !mem_we_n)) |-> $stable(mem_addr));

  // R8: no drive while memory outputs may be on
  p_no_clash_r8: assert property (@(posedge clk) disable iff (rst)
    drv_en |-> mem_oe_n);

  // R9: turnaround after a read
  p_turn_gap_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_oe_n) |-> (!req_ready && !drv_en));

  p_turn_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_oe_n) |=> (mem_ce_n && !drv_en));

endmodule

bind asram_ctrl asram_ctrl_chk #(.AW(AW), .WR_MODE(WR_MODE)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_ready (req_ready),
  .rd_valid  (rd_valid),
  .mem_addr  (mem_addr),
  .mem_ce_n  (mem_ce_n),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n),
  .drv_en    (drv_en)
);

// File: tb/sim_asram_ctrl.sv
`timescale 1ns/1ps

module sim_asram_model #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  inout  wire  [DW-1:0] dq,
  output int            clashes,
  output int            last_term
);

  logic [DW-1:0] mem [0:(1<<AW)-1];
  int n_clash = 0;
  int term = 0;

  wire drive = !ce_n && !oe_n && we_n;
  wire wr_on = !ce_n && !we_n;

  assign dq = drive ? mem[addr] : {DW{1'bz}};
  assign clashes = n_clash;
  assign last_term = term;

  always @(negedge wr_on) begin
    mem[addr] = dq;
    if (we_n && !ce_n) term = 1;
    else if (ce_n && !we_n) term = 2;
    else term = 3;
  end

  always @(negedge clk) begin
    if (drive && (dq !== mem[addr])) n_clash = n_clash + 1;
  end

endmodule

module sim_asram_ctrl;

  localparam int AW = 8;
  localparam int DW = 8;
  localparam int RD = 3;
  localparam int WR = 3;
  localparam int TA = 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;

  logic rdy0, rdy1, rv0, rv1, ce0, ce1, we0, we1, oe0, oe1;
  logic [DW-1:0] rd0, rd1;
  logic [AW-1:0] ad0, ad1;
  wire  [DW-1:0] dq0, dq1;
  int clash0, clash1, term0, term1;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  asram_ctrl #(.AW(AW), .DW(DW), .RD_CYC(RD), .WR_CYC(WR), .TA_CYC(TA), .WR_MODE(0)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(rdy0),
    .rd_valid(rv0), .rd_data(rd0), .mem_addr(ad0), .mem_ce_n(ce0),
    .mem_we_n(we0), .mem_oe_n(oe0), .mem_dq(dq0));

  asram_ctrl #(.AW(AW), .DW(DW), .RD_CYC(RD), .WR_CYC(WR), .TA_CYC(TA), .WR_MODE(1)) u1 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(rdy1),
    .rd_valid(rv1), .rd_data(rd1), .mem_addr(ad1), .mem_ce_n(ce1),
    .mem_we_n(we1), .mem_oe_n(oe1), .mem_dq(dq1));

  sim_asram_model #(.AW(AW), .DW(DW)) m0 (.clk(clk), .addr(ad0), .ce_n(ce0),
    .we_n(we0), .oe_n(oe0), .dq(dq0), .clashes(clash0), .last_term(term0));
  sim_asram_model #(.AW(AW), .DW(DW)) m1 (.clk(clk), .addr(ad1), .ce_n(ce1),
    .we_n(we1), .oe_n(oe1), .dq(dq1), .clashes(clash1), .last_term(term1));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    while (!rdy0) @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(ce0 && we0 && oe0 && ce1 && we1 && oe1 && rdy0 && !rv0, "R1 in reset",
        {ce0, we0, oe0, rdy0, rv0}, 5'b11110);
    rst = 1'b0;
    @(negedge clk);
    chk(ce0 && we0 && oe0 && ce1 && we1 && oe1 && rdy0 && rdy1 && !rv0 && !rv1,
        "R1 after reset", {ce0, we0, oe0, rdy0, rv0}, 5'b11110);
  endtask

  task automatic t_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    issue(1'b1, a, d);
    for (int i = 0; i < WR; i++) begin
      chk(!ce0 && !we0 && oe0 && !ce1 && !we1 && oe1, "R5 write strobes",
          {ce0, we0, oe0, ce1, we1, oe1}, 6'b001001);
      chk(ad0 == a && ad1 == a && !rdy0 && !rdy1, "R7/R10 addr held, busy",
          {ad0, rdy0}, {a, 1'b0});
      @(negedge clk);
    end
    chk(we0 && !ce0, "R6 mode0 we rises first", {ce0, we0}, 2'b01);
    chk(ce1 && !we1, "R6 mode1 ce rises first", {ce1, we1}, 2'b10);
    chk(term0 == 1 && term1 == 2, "R6 model terminator", {term0[3:0], term1[3:0]}, 8'h12);
    chk(ad0 == a && ad1 == a, "R7 addr in hold cycle", ad0, a);
    @(negedge clk);
    chk(ce0 && we0 && ce1 && we1 && rdy0 && rdy1, "R2 idle after write",
        {ce0, we0, rdy0}, 3'b111);
  endtask

  task automatic t_read(input logic [AW-1:0] a, input logic [DW-1:0] exp);
    issue(1'b0, a, '0);
    for (int i = 0; i < RD; i++) begin
      chk(!ce0 && !oe0 && we0 && !ce1 && !oe1 && we1 && ad0 == a && ad1 == a,
          "R3 read strobes", {ce0, oe0, we0, ad0}, {3'b001, a});
      @(negedge clk);
    end
    chk(rv0 && rv1 && rd0 == exp && rd1 == exp, "R4/R11 read data", {rv0, rd0, rd1},
        {1'b1, exp, exp});
    for (int j = 0; j < TA; j++) begin
      chk(!rdy0 && !rdy1 && ce0 && oe0 && we0 && ce1 && oe1 && we1, "R9 turnaround",
          {rdy0, ce0, oe0, we0}, 4'b0111);
      @(negedge clk);
    end
    chk(!rv0 && !rv1 && rdy0 && ce0, "R4 single pulse, R2 idle", {rv0, rdy0, ce0}, 3'b011);
  endtask

  task automatic t_busy_ignore();
    t_write(8'h40, 8'h5A);
    issue(1'b1, 8'h41, 8'h11);
    req_valid = 1'b1;
    req_write = 1'b1;
    req_addr  = 8'h40;
    req_wdata = 8'hC3;
    for (int i = 0; i < WR + 1; i++) begin
      chk(!rdy0 && !rdy1, "R10 busy while request held", rdy0, 1'b0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk(ce0 && we0 && ce1 && we1, "R10 stray request not accepted", {ce0, we0}, 2'b11);
    t_read(8'h40, 8'h5A);
    t_read(8'h41, 8'h11);
  endtask

  task automatic t_read_then_write();
    int k;
    bit got;
    t_write(8'h22, 8'hA7);
    issue(1'b0, 8'h22, '0);
    req_valid = 1'b1;
    req_write = 1'b1;
    req_addr  = 8'h23;
    req_wdata = 8'h3C;
    k = 1;
    got = 1'b0;
    while (we0 && k < 40) begin
      if (k == RD + 1) begin
        chk(rv0 && rv1 && rd0 == 8'hA7 && rd1 == 8'hA7, "R4/R11 read before write",
            rd0, 8'hA7);
        got = 1'b1;
      end
      @(negedge clk);
      k++;
    end
    req_valid = 1'b0;
    chk(got, "R4 read completed before pending write", got, 1'b1);
    chk(k == RD + TA + 2, "R9 write start after turnaround", k, RD + TA + 2);
    while (!rdy0) @(negedge clk);
    t_read(8'h23, 8'h3C);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_write(8'h01, 8'h96);
    t_write(8'hFE, 8'h0F);
    t_write(8'h80, 8'hF0);
    t_read(8'hFE, 8'h0F);
    t_read(8'h01, 8'h96);
    t_write(8'h01, 8'h69);
    t_read(8'h01, 8'h69);
    t_read(8'h80, 8'hF0);
    t_busy_ignore();
    t_read_then_write();
    repeat (2) @(negedge clk);
    chk(clash0 == 0 && clash1 == 0, "R8 no bus contention", clash0 + clash1, 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule